// File: doc/BRIEF.md
# Register-Mapped PWM with Update Lock

This block is a single-channel pulse-width modulator controlled through a small 32-bit register bus. Software programs a period and a duty count in clock cycles and a control word. The control word enables the channel, picks the output level used during the duty window, and picks the output level used outside the window and while the channel is stopped. A free-running counter steps through each period. The output shows the duty level while the count is below the duty value.

New period, duty and polarity settings never reach the waveform in the middle of a period. Each setting waits in a holding stage and is committed only at a period boundary. A lock bit in the control word keeps the holding stage from committing, so software can stage period, duty and polarity over several writes. After software clears the lock, all three settings start together at the next boundary.

Top module: `pwm_lock_core`

## Requirements
- R1: After reset, the counter, period, duty and control registers read 0 and `pwm_out` is low.
- R2: Period (offset 0x04), duty (0x08) and control (0x0C) read back the last value written to them. The counter (0x00) reads the live count. `rdata` is combinational on `addr` while `rd_en` is 1 and is 0 while `rd_en` is 0.
- R3: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. In any other case the counter is held at 0.
- R4: While the channel runs, the counter steps from 0 to period-1 and then wraps to 0. With a period of 0 or 1, it stays at 0.
- R5: While the channel runs, the output is at the duty level when count < duty and at the idle level otherwise. With duty >= period the output stays at the duty level. With duty = 0 it stays at the idle level.
- R6: Control bit 3 sets the duty level and control bit 4 sets the idle level (1 = high, 0 = low). Normal polarity is bit 3 = 1 with bit 4 = 0, and inverted polarity is the reverse.
- R7: While the channel is stopped and unlocked, the held settings are committed every cycle. The output then shows the bit-4 level one cycle after the control write.
- R8: While the channel runs and is unlocked, a change to period, duty or polarity takes effect only at the next period boundary (the cycle after the count reaches period-1).
- R9: While control bit 6 (lock) is 1, period, duty and polarity writes are accepted and read back but do not reach the waveform, including across period boundaries.
- R10: After the lock is cleared, the staged period, duty and polarity take effect together at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read enable for `rdata` |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write is visible on `rdata` one clock after the write edge. A commit of settings changes the waveform on the edge that follows the boundary cycle. The counter wraps on that same edge. The bench drives inputs on the falling edge and steps a behavioural model on each rising edge, using the same pre-edge inputs the design sees. It then compares `pwm_out` and `rdata` shortly after the next falling edge, when every one-cycle result has settled. Because the model advances in step with the clock, a commit that lands one cycle early or late is reported.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;
  // Register byte offsets
  localparam logic [3:0] OFS_COUNT  = 4'h0;
  localparam logic [3:0] OFS_PERIOD = 4'h4;
  localparam logic [3:0] OFS_DUTY   = 4'h8;
  localparam logic [3:0] OFS_CTRL   = 4'hC;
  // Control word bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_CONT = 1;
  localparam int BIT_DLVL = 3;
  localparam int BIT_ILVL = 4;
  localparam int BIT_LOCK = 6;
endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] live_cnt,
  output logic [DW-1:0] period_q,
  output logic [DW-1:0] duty_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] rdata
);
  import pwm_lock_pkg::*;

  logic hit_period, hit_duty, hit_ctrl, hit_count;
  assign hit_count  = (addr == AW'(OFS_COUNT));
  assign hit_period = (addr == AW'(OFS_PERIOD));
  assign hit_duty   = (addr == AW'(OFS_DUTY));
  assign hit_ctrl   = (addr == AW'(OFS_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      if (hit_period) period_q <= wdata;
      if (hit_duty)   duty_q   <= wdata;
      if (hit_ctrl)   ctrl_q   <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_count)  rdata = live_cnt;
      if (hit_period) rdata = period_q;
      if (hit_duty)   rdata = duty_q;
      if (hit_ctrl)   rdata = ctrl_q;
    end
  end
endmodule

// File: rtl/pwm_lock_shadow.sv
module pwm_lock_shadow #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [DW-1:0] period_in,
  input  logic [DW-1:0] duty_in,
  input  logic          dlvl_in,
  input  logic          ilvl_in,
  output logic [DW-1:0] act_period,
  output logic [DW-1:0] act_duty,
  output logic          act_dlvl,
  output logic          act_ilvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= '0;
      act_duty   <= '0;
      act_dlvl   <= 1'b0;
      act_ilvl   <= 1'b0;
    end else if (commit) begin
      act_period <= period_in;
      act_duty   <= duty_in;
      act_dlvl   <= dlvl_in;
      act_ilvl   <= ilvl_in;
    end
  end
endmodule

// File: rtl/pwm_lock_counter.sv
module pwm_lock_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] act_period,
  input  logic [DW-1:0] act_duty,
  input  logic          act_dlvl,
  input  logic          act_ilvl,
  output logic [DW-1:0] cnt,
  output logic          period_end,
  output logic          pwm_out
);
  localparam int XW = DW + 1;

  // Last cycle of a period: the next count would reach the period value.
  function automatic logic last_tick(input logic [DW-1:0] c, input logic [DW-1:0] p);
    logic [XW-1:0] nxt;
    nxt = {1'b0, c} + XW'(1);
    return nxt >= {1'b0, p};
  endfunction

  function automatic logic duty_window(input logic [DW-1:0] c, input logic [DW-1:0] d);
    return c < d;
  endfunction

  assign period_end = run && last_tick(cnt, act_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (period_end) cnt <= '0;
    else                 cnt <= cnt + DW'(1);
  end

  always_comb begin
    if (run && duty_window(cnt, act_duty)) pwm_out = act_dlvl;
    else                                   pwm_out = act_ilvl;
  end
endmodule

// File: rtl/pwm_lock_core.sv
module pwm_lock_core #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  import pwm_lock_pkg::*;

  logic [DATA_W-1:0] period_q, duty_q, ctrl_q, live_cnt;
  logic [DATA_W-1:0] act_period, act_duty;
  logic act_dlvl, act_ilvl;
  logic run_w, lock_w, period_end, commit_w;

  assign run_w    = ctrl_q[BIT_EN] & ctrl_q[BIT_CONT];
  assign lock_w   = ctrl_q[BIT_LOCK];
  assign commit_w = !lock_w && (!run_w || period_end);

  pwm_lock_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .live_cnt(live_cnt), .period_q(period_q),
    .duty_q(duty_q), .ctrl_q(ctrl_q), .rdata(rdata)
  );

  pwm_lock_shadow #(.DW(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .commit(commit_w),
    .period_in(period_q), .duty_in(duty_q),
    .dlvl_in(ctrl_q[BIT_DLVL]), .ilvl_in(ctrl_q[BIT_ILVL]),
    .act_period(act_period), .act_duty(act_duty),
    .act_dlvl(act_dlvl), .act_ilvl(act_ilvl)
  );

  pwm_lock_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_w),
    .act_period(act_period), .act_duty(act_duty),
    .act_dlvl(act_dlvl), .act_ilvl(act_ilvl),
    .cnt(live_cnt), .period_end(period_end), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_lock_chk.sv
module pwm_lock_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          lock,
  input logic          boundary,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] act_period,
  input logic [DW-1:0] act_duty,
  input logic          ctrl_ilvl,
  input logic          pwm_out
);
  assert_cnt_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_period != '0) |-> (cnt < act_period));

  assert_mid_period_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> ($stable(act_period) && $stable(act_duty)));

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(act_period) && $stable(act_duty)));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !lock && $past(!run && !lock)) |-> (pwm_out == $past(ctrl_ilvl)));
endmodule

bind pwm_lock_core pwm_lock_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .lock(lock_w), .boundary(period_end),
  .cnt(live_cnt), .act_period(act_period), .act_duty(act_duty),
  .ctrl_ilvl(ctrl_q[4]), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_lock_core.sv
module tb_pwm_lock_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b1;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // Behavioural reference state
  longint m_wper = 0, m_wduty = 0, m_wctrl = 0;
  longint m_aper = 0, m_aduty = 0, m_cnt = 0;
  bit     m_adl = 0, m_ail = 0;

  always #4 clk = ~clk;

  pwm_lock_core dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always @(posedge clk) begin
    bit running, locked, wrap;
    if (!rst_n) begin
      m_wper = 0; m_wduty = 0; m_wctrl = 0;
      m_aper = 0; m_aduty = 0; m_cnt = 0; m_adl = 0; m_ail = 0;
    end else begin
      running = ((m_wctrl & 3) == 3);
      locked  = m_wctrl[6];
      wrap    = running && (m_cnt + 1 >= m_aper);
      if (!locked && (!running || wrap)) begin
        m_aper = m_wper; m_aduty = m_wduty;
        m_adl = m_wctrl[3]; m_ail = m_wctrl[4];
      end
      if (!running || wrap) m_cnt = 0;
      else                  m_cnt = m_cnt + 1;
      if (wr_en) begin
        case (addr)
          4'h4: m_wper  = wdata;
          4'h8: m_wduty = wdata;
          4'hC: m_wctrl = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic bit model_out();
    if (((m_wctrl & 3) == 3) && (m_cnt < m_aduty)) return m_adl;
    return m_ail;
  endfunction

  function automatic longint model_read(input logic [3:0] a);
    if (!rd_en) return 0;
    case (a)
      4'h0: return m_cnt;
      4'h4: return m_wper;
      4'h8: return m_wduty;
      4'hC: return m_wctrl;
      default: return 0;
    endcase
  endfunction

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      tests++;
      if (pwm_out !== model_out()) begin
        fails++;
        $display("FAIL %s pwm_out actual=%0b expected=%0b cnt=%0d", cur_req, pwm_out, model_out(), m_cnt);
      end
      tests++;
      if (longint'(rdata) != model_read(addr)) begin
        fails++;
        $display("FAIL %s rdata@%0h actual=%0d expected=%0d", cur_req, addr, rdata, model_read(addr));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    addr = 4'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tests++;
    if (pwm_out !== 1'b0 || rdata !== 32'd0) begin
      fails++;
      $display("FAIL R1 reset actual=%0b/%0d expected=0/0", pwm_out, rdata);
    end
    cur_req = "R1"; rd(4'h4); rd(4'h8); rd(4'hC);

    // R2: readback of written registers and live count
    cur_req = "R2";
    wr(4'h4, 32'd10); wr(4'h8, 32'd4);
    rd(4'h4); rd(4'h8);

    // R3: enable alone does not run
    cur_req = "R3";
    wr(4'hC, 32'h09); idle(15);
    wr(4'hC, 32'h0A); idle(15);

    // R4 / R5: normal polarity running
    cur_req = "R4";
    wr(4'hC, 32'h0B); rd(4'hC); idle(35);

    // R6: inverted polarity
    cur_req = "R6";
    wr(4'hC, 32'h13); idle(30);

    // R8: mid-period changes wait for boundary
    cur_req = "R8";
    idle(3); wr(4'h8, 32'd7); idle(5); wr(4'h4, 32'd13); idle(40);
    wr(4'hC, 32'h0B); idle(30);

    // R5: duty >= period and duty = 0
    cur_req = "R5";
    wr(4'h8, 32'd20); idle(35);
    wr(4'h8, 32'd0); idle(35);
    wr(4'h8, 32'd5); idle(30);

    // R9: lock holds staged values across boundaries
    cur_req = "R9";
    wr(4'hC, 32'h4B);
    wr(4'h4, 32'd6); wr(4'h8, 32'd2); wr(4'hC, 32'h53);
    rd(4'h4); rd(4'h8); idle(45);

    // R10: unlock commits all together at the next boundary
    cur_req = "R10";
    wr(4'hC, 32'h13); idle(40);

    // R4: period 1 and 0
    cur_req = "R4";
    wr(4'h4, 32'd1); wr(4'h8, 32'd1); idle(10);
    wr(4'h4, 32'd0); idle(10);
    wr(4'h4, 32'd8); wr(4'h8, 32'd3); idle(20);

    // R7: stopped channel follows idle level
    cur_req = "R7";
    wr(4'hC, 32'h10); idle(6);
    wr(4'hC, 32'h08); idle(6);
    wr(4'hC, 32'h18); idle(6);

    // R9 while stopped: lock still blocks commit
    cur_req = "R9";
    wr(4'hC, 32'h40); wr(4'hC, 32'h50); idle(6);
    cur_req = "R10";
    wr(4'hC, 32'h10); idle(6);

    // R2: final readback with read disabled then enabled
    cur_req = "R2";
    rd_en = 1'b0; idle(3); rd_en = 1'b1;
    rd(4'h4); rd(4'h8); rd(4'hC);

    summary();
    $finish;
  end
endmodule